// File: doc/BRIEF.md
# Dual-Compare One-Shot Pulse Generator

This block watches one of two free-running timer counts and produces a single pulse on its output. The pulse rises the first time the selected count equals a leading-edge compare value and falls when the count later equals a trailing-edge compare value. Once the trailing edge has been driven the output stays low, whatever the timer does next.

Software-style control arrives as plain inputs: a module enable, a mode field with a write strobe, a timer-select bit, the two compare values and an interrupt enable. The trailing-edge match sets a sticky interrupt flag, which holds until a clear pulse. A fresh pulse is launched only by strobing the one-shot mode code in again. The compare values may be changed freely before that strobe.

All outputs are registered except the interrupt request, which combines the flag with the interrupt enable.

Top module: `oneshot_cmp`

## Requirements
- R1: While rst_n is low at a clock edge, pulse_out, irq_flag and irq_req are 0 in the following cycle.
- R2: A cycle with en=1, mode_wr=1 and mode=3'b100 arms the unit from any state. pulse_out is 0 in the next cycle.
- R3: tsel=0 compares tmr_a and tsel=1 compares tmr_b. The unselected count has no effect.
- R4: While armed, the first cycle in which the selected count equals cmp_lead drives pulse_out to 1 in the next cycle.
- R5: While the output is high, the first cycle in which the selected count equals cmp_trail drives pulse_out to 0 in the next cycle and sets irq_flag in that same next cycle.
- R6: After the trailing edge, later matches on either compare value produce no further pulse and no further flag set, until the next arming write.
- R7: irq_flag stays set until irq_clr is 1 at a clock edge. irq_clr at the same edge as a trailing match leaves irq_flag at 0.
- R8: irq_req is 1 exactly when irq_flag and irq_en are both 1.
- R9: With en=0, pulse_out is 0 in the next cycle and the unit returns to idle. After en returns, no pulse occurs until an arming write.
- R10: When cmp_lead equals cmp_trail, the leading match produces no high phase. The unit goes straight to done and sets irq_flag.
- R11: A mode write with any code other than 3'b100 returns the unit to idle with pulse_out 0, and later matches produce no pulse.
- R12: A trailing-value match while armed and still low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable |
| mode_wr | input | 1 | Strobe: mode field written this cycle |
| mode | input | 3 | Mode code; 3'b100 is one-shot |
| tsel | input | 1 | Time base select: 0 = tmr_a, 1 = tmr_b |
| cmp_lead | input | TW | Leading-edge compare value |
| cmp_trail | input | TW | Trailing-edge compare value |
| tmr_a | input | TW | Timer count A |
| tmr_b | input | TW | Timer count B |
| irq_clr | input | 1 | Clears the interrupt flag |
| irq_en | input | 1 | Interrupt enable |
| pulse_out | output | 1 | Pulse output |
| irq_flag | output | 1 | Sticky trailing-edge flag |
| irq_req | output | 1 | Interrupt request |

## Verification
Two things can fall in the same cycle: the flag set caused by a trailing match and a clear pulse. The bench places irq_clr on exactly the cycle in which the selected count reaches cmp_trail and expects the flag to remain 0 afterwards. It also expects a clear issued on a later cycle to drop a flag that is already set. An arming write that lands during the high phase is also provoked. The bench judges both cases by comparing against a per-cycle behavioural model and by counting rising edges on pulse_out.

// File: rtl/oneshot_pkg.sv
// Shared types for the one-shot compare unit.
// Assumes: two-bit state encoding; no other users.
package oneshot_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIGH  = 2'd2,
        ST_DONE  = 2'd3
    } os_state_t;

    localparam logic [2:0] MODE_ONESHOT = 3'b100;
endpackage

// File: rtl/oneshot_match.sv
// Selects one of two timer counts and compares it with both compare values.
// Assumes: counts and compare values share width TW; purely combinational.
module oneshot_match #(
    parameter int TW = 16
) (
    input  logic          tsel,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic [TW-1:0] cmp_lead,
    input  logic [TW-1:0] cmp_trail,
    output logic [TW-1:0] sel_cnt,
    output logic          hit_lead,
    output logic          hit_trail,
    output logic          same_cmp
);
    // Time-base mux and the two equality comparators.
    always_comb begin
        sel_cnt   = tsel ? tmr_b : tmr_a;
        hit_lead  = (sel_cnt == cmp_lead);
        hit_trail = (sel_cnt == cmp_trail);
        same_cmp  = (cmp_lead == cmp_trail);
    end
endmodule

// File: rtl/oneshot_seq.sv
// Sequencer: idle -> armed (low) -> high -> done, and the registered pulse pin.
// Assumes: wr_arm and wr_other are mutually exclusive single-cycle strobes.
module oneshot_seq
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      wr_arm,
    input  logic      wr_other,
    input  logic      hit_lead,
    input  logic      hit_trail,
    input  logic      same_cmp,
    output logic      pulse_q,
    output logic      set_req,
    output os_state_t state
);
    os_state_t state_n;
    logic      pulse_n;

    // Next-state, next-output and flag-set decision.
    always_comb begin
        state_n = state;
        pulse_n = pulse_q;
        set_req = 1'b0;
        if (!en) begin
            state_n = ST_IDLE;
            pulse_n = 1'b0;
        end else if (wr_arm) begin
            state_n = ST_ARMED;
            pulse_n = 1'b0;
        end else if (wr_other) begin
            state_n = ST_IDLE;
            pulse_n = 1'b0;
        end else begin
            unique case (state)
                ST_ARMED: if (hit_lead) begin
                    if (same_cmp) begin
                        state_n = ST_DONE;
                        set_req = 1'b1;
                    end else begin
                        state_n = ST_HIGH;
                        pulse_n = 1'b1;
                    end
                end
                ST_HIGH: if (hit_trail) begin
                    state_n = ST_DONE;
                    pulse_n = 1'b0;
                    set_req = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // State and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pulse_q <= 1'b0;
        end else begin
            state   <= state_n;
            pulse_q <= pulse_n;
        end
    end
endmodule

// File: rtl/oneshot_flag.sv
// Sticky interrupt flag with clear, and the gated interrupt request.
// Assumes: clear wins over a set arriving in the same cycle.
module oneshot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr,
    input  logic irq_en,
    output logic flag_q,
    output logic req
);
    // Flag register: clear, then set, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (clr)     flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
    end

    // Request only when enabled.
    always_comb req = flag_q & irq_en;
endmodule

// File: rtl/oneshot_cmp.sv
// Top: dual-compare one-shot pulse generator.
// Assumes: timer counts are supplied externally and stable around the clock edge.
module oneshot_cmp
    import oneshot_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode_wr,
    input  logic [2:0]    mode,
    input  logic          tsel,
    input  logic [TW-1:0] cmp_lead,
    input  logic [TW-1:0] cmp_trail,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic          irq_clr,
    input  logic          irq_en,
    output logic          pulse_out,
    output logic          irq_flag,
    output logic          irq_req
);
    logic [TW-1:0] sel_cnt;
    logic          hit_lead, hit_trail, same_cmp;
    logic          wr_arm, wr_other, set_req;
    os_state_t     state;

    // Decode the mode write strobe.
    always_comb begin
        wr_arm   = mode_wr && (mode == MODE_ONESHOT);
        wr_other = mode_wr && (mode != MODE_ONESHOT);
    end

    oneshot_match #(.TW(TW)) u_match (
        .tsel(tsel), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .cmp_lead(cmp_lead), .cmp_trail(cmp_trail),
        .sel_cnt(sel_cnt), .hit_lead(hit_lead),
        .hit_trail(hit_trail), .same_cmp(same_cmp)
    );

    oneshot_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en(en),
        .wr_arm(wr_arm), .wr_other(wr_other),
        .hit_lead(hit_lead), .hit_trail(hit_trail), .same_cmp(same_cmp),
        .pulse_q(pulse_out), .set_req(set_req), .state(state)
    );

    oneshot_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr(irq_clr),
        .irq_en(irq_en), .flag_q(irq_flag), .req(irq_req)
    );
endmodule

// File: rtl/oneshot_cmp_chk.sv
// Checker for oneshot_cmp, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module oneshot_cmp_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          mode_wr,
    input logic [2:0]    mode,
    input logic [TW-1:0] cmp_lead,
    input logic [TW-1:0] sel_cnt,
    input logic          irq_clr,
    input logic          pulse_out,
    input logic          irq_flag
);
    // R9
    en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_out);

    // R2
    arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode_wr && mode == 3'b100) |=> !pulse_out);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq_flag);

    // R4
    rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(sel_cnt == cmp_lead));

    // R5
    fall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_out) && $past(en) && !$past(mode_wr) && !$past(irq_clr))
        |-> irq_flag);
endmodule

bind oneshot_cmp oneshot_cmp_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_wr(mode_wr), .mode(mode),
    .cmp_lead(cmp_lead), .sel_cnt(sel_cnt), .irq_clr(irq_clr),
    .pulse_out(pulse_out), .irq_flag(irq_flag)
);

// File: tb/sim_oneshot_cmp.sv
module sim_oneshot_cmp;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, mode_wr = 1'b0, tsel = 1'b0;
    logic [2:0]    mode = 3'b000;
    logic [TW-1:0] cmp_lead = '0, cmp_trail = '0, tmr_a = '0, tmr_b = '0;
    logic          irq_clr = 1'b0, irq_en = 1'b0;
    logic          pulse_out, irq_flag, irq_req;

    int    checks = 0, errors = 0, rises = 0;
    bit    prev_p = 1'b0, done = 1'b0;
    string tag = "R1";
    // reference model: 0 idle, 1 armed, 2 high, 3 done
    int    m_st = 0;
    bit    m_p = 1'b0, m_f = 1'b0;

    always #2 clk = ~clk;

    oneshot_cmp #(.TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_wr(mode_wr), .mode(mode),
        .tsel(tsel), .cmp_lead(cmp_lead), .cmp_trail(cmp_trail),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .irq_clr(irq_clr), .irq_en(irq_en),
        .pulse_out(pulse_out), .irq_flag(irq_flag), .irq_req(irq_req)
    );

    task automatic model_step();
        bit set = 1'b0;
        int sc = tsel ? int'(tmr_b) : int'(tmr_a);
        if (!rst_n) begin
            m_st = 0; m_p = 0; m_f = 0;
            return;
        end
        if (!en) begin m_st = 0; m_p = 0; end
        else if (mode_wr) begin m_st = (mode == 3'b100) ? 1 : 0; m_p = 0; end
        else if (m_st == 1 && sc == int'(cmp_lead)) begin
            if (cmp_lead == cmp_trail) begin m_st = 3; set = 1; end
            else begin m_st = 2; m_p = 1; end
        end else if (m_st == 2 && sc == int'(cmp_trail)) begin
            m_st = 3; m_p = 0; set = 1;
        end
        if (irq_clr) m_f = 0;
        else if (set) m_f = 1;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        checks++;
        if (pulse_out !== m_p || irq_flag !== m_f || irq_req !== (m_f && irq_en)) begin
            errors++;
            $display("FAIL %s pulse=%b exp %b flag=%b exp %b req=%b exp %b",
                     tag, pulse_out, m_p, irq_flag, m_f, irq_req, m_f && irq_en);
        end
        if (pulse_out && !prev_p) rises++;
        prev_p = pulse_out;
        mode_wr = 0;
        irq_clr = 0;
    endtask

    task automatic expect_int(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic write_mode(logic [2:0] m);
        mode = m; mode_wr = 1; cyc();
    endtask

    // sweep the selected timer upward; the other is parked
    task automatic sweep(bit use_b, int lo, int hi);
        for (int i = lo; i <= hi; i++) begin
            if (use_b) tmr_b = TW'(i); else tmr_a = TW'(i);
            cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tag = "R1"; cyc(); cyc(); cyc();
        expect_int("R1 pulse", int'(pulse_out), 0);
        expect_int("R1 flag", int'(irq_flag), 0);
        rst_n = 1; en = 1; irq_en = 1;

        // basic pulse on timer A
        cmp_lead = 10; cmp_trail = 14; tsel = 0; tmr_b = 10;
        tag = "R2"; write_mode(3'b100);
        expect_int("R2 low after arm", int'(pulse_out), 0);
        tag = "R12"; tmr_a = 14; cyc(); cyc();
        expect_int("R12 trail ignored while armed", int'(irq_flag), 0);
        rises = 0; tag = "R4"; sweep(0, 0, 12);
        expect_int("R4 one rise", rises, 1);
        expect_int("R4 high", int'(pulse_out), 1);
        tag = "R5"; sweep(0, 13, 16);
        expect_int("R5 low", int'(pulse_out), 0);
        expect_int("R5 flag", int'(irq_flag), 1);
        tag = "R8"; irq_en = 0; cyc();
        expect_int("R8 req masked", int'(irq_req), 0);
        irq_en = 1; cyc();
        expect_int("R8 req", int'(irq_req), 1);
        rises = 0; tag = "R6"; sweep(0, 0, 20);
        expect_int("R6 no second pulse", rises, 0);
        tag = "R7"; cyc();
        expect_int("R7 sticky", int'(irq_flag), 1);
        irq_clr = 1; cyc();
        expect_int("R7 cleared", int'(irq_flag), 0);

        // time base B; A parked on the match values
        tag = "R3"; tsel = 1; tmr_a = 10; cmp_lead = 30; cmp_trail = 33;
        write_mode(3'b100);
        tmr_a = 30; rises = 0; sweep(1, 20, 31);
        expect_int("R3 rise from B", rises, 1);
        tmr_a = 33; cyc();
        expect_int("R3 A ignored", int'(pulse_out), 1);
        tmr_b = 32; cyc();
        // clear in the same cycle as the trailing match
        tag = "R7"; tmr_b = 33; irq_clr = 1; cyc();
        expect_int("R7 clr beats set", int'(irq_flag), 0);
        expect_int("R7 pulse fell", int'(pulse_out), 0);

        // equal compare values
        tag = "R10"; tsel = 0; cmp_lead = 7; cmp_trail = 7;
        write_mode(3'b100);
        rises = 0; sweep(0, 0, 9);
        expect_int("R10 no high", rises, 0);
        expect_int("R10 flag", int'(irq_flag), 1);
        irq_clr = 1; cyc();

        // disable mid-pulse
        tag = "R9"; cmp_lead = 3; cmp_trail = 8;
        write_mode(3'b100);
        sweep(0, 0, 4);
        expect_int("R9 high before", int'(pulse_out), 1);
        en = 0; cyc();
        expect_int("R9 low when off", int'(pulse_out), 0);
        en = 1; rises = 0; sweep(0, 0, 10);
        expect_int("R9 no pulse after re-enable", rises, 0);

        // re-arm from the high state
        tag = "R2"; write_mode(3'b100);
        sweep(0, 0, 4);
        write_mode(3'b100);
        expect_int("R2 re-arm from high", int'(pulse_out), 0);
        rises = 0; sweep(0, 0, 9);
        expect_int("R2 new pulse", rises, 1);

        // other mode code
        tag = "R11"; write_mode(3'b100);
        write_mode(3'b010);
        rises = 0; sweep(0, 0, 10);
        expect_int("R11 no pulse", rises, 0);
        expect_int("R11 low", int'(pulse_out), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule